// File: doc/BRIEF.md
# Coprocessor Interrupt Arbiter

This block runs ahead of every instruction fetch of a coprocessor core. On each fetch strobe it decides one of four things: the core is held and nothing happens, the non-maskable interrupt is taken, one of three maskable sources is taken, or nothing is taken and the fetch goes ahead. It keeps two flag registers. A status register records every source that has been taken. An in-service register keeps a taken source from firing again until software acknowledges it.

When a source is taken, the block sends the core a one-cycle vector request. The request carries a source ID and separate non-maskable and maskable vector selects. If the core was parked in its wait-for-interrupt state, a program-counter bump pulse comes with the request. The vector request has no back-pressure. The core must act on the pulse in the cycle it appears. The arbiter never repeats it, because the source's in-service bit is already set.

Top module: `cop_irq_arbiter`

## Requirements
- R1: After reset, both flag registers read zero, and the vector request, both selects and the bump pulse are low.
- R2: While bit 5 or bit 6 of `ctrl_i` is set, `halt_o` is high and a fetch strobe takes no source and changes no flag.
- R3: The non-maskable source is requested by `ctrl_i` bit 4. It is taken on a fetch when in-service bit 4 is clear, whatever the state of `irq_dis_i`. Taking it gives source ID 0 and `vec_nmi_o`, and it sets status bit 4 and in-service bit 4.
- R4: While in-service bit 4 is set, a pending non-maskable request is not taken again, and the maskable sources are considered instead.
- R5: Maskable sources are considered only when `irq_dis_i` is low.
- R6: At most one source is taken per fetch. Among the maskable sources, the timer (ID 1) wins over DMA (ID 2), and DMA wins over the host request (ID 3). A maskable take drives `vec_irq_o`.
- R7: The timer needs `tmr_req_i` and enable bit 6. DMA needs `dma_req_i` and enable bit 5. The host source needs `ctrl_i` bit 7 and enable bit 7. Each also needs its in-service bit clear, at the same position as its enable bit. A take sets that bit in both flag registers.
- R8: If `wait_i` is high on a fetch that takes a source, `pc_bump_o` pulses together with the vector request. Otherwise it stays low.
- R9: A one in `isr_ack_i` clears that in-service bit, and a one in `sts_clr_i` clears that status bit. If a take sets the same bit in the same cycle, the set wins.
- R10: All decisions appear on the outputs one clock after the fetch strobe. Without a fetch strobe nothing is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_i | input | 1 | Decision strobe ahead of an instruction fetch |
| ctrl_i | input | 8 | Control: bit 7 host request, bits 6/5 hold, bit 4 NMI request |
| en_i | input | 8 | Enables: bit 7 host, bit 6 timer, bit 5 DMA |
| tmr_req_i | input | 1 | Timer request line |
| dma_req_i | input | 1 | DMA request line |
| irq_dis_i | input | 1 | Core interrupt-disable flag |
| wait_i | input | 1 | Core is in wait-for-interrupt |
| isr_ack_i | input | 8 | Write-one-to-clear for in-service bits |
| sts_clr_i | input | 8 | Write-one-to-clear for status bits |
| vec_valid_o | output | 1 | One-cycle vector request |
| vec_src_o | output | 2 | Taken source: 0 NMI, 1 timer, 2 DMA, 3 host |
| vec_nmi_o | output | 1 | Non-maskable vector select |
| vec_irq_o | output | 1 | Maskable vector select |
| pc_bump_o | output | 1 | Program-counter increment pulse on wake-up |
| halt_o | output | 1 | Core held (combinational from `ctrl_i`) |
| status_o | output | 8 | Taken-source status register |
| in_service_o | output | 8 | In-service register |

## Verification
`halt_o` is combinational, so the bench samples it one nanosecond after it drives `ctrl_i`. Every other result is registered and is due exactly one clock after the fetch strobe or clear write that causes it. The bench drives each stimulus on a falling edge and lets one rising edge pass. On the next falling edge it compares every output against a behavioural model that was advanced by the same stimulus. A pulse that comes a cycle late therefore fails on two successive comparisons.

// File: rtl/cop_irq_pkg.sv
package cop_irq_pkg;
  localparam int REG_W    = 8;
  localparam int NMI_BIT  = 4;
  localparam int DMA_BIT  = 5;
  localparam int TMR_BIT  = 6;
  localparam int HOST_BIT = 7;
  localparam int HOLD_A   = 5;
  localparam int HOLD_B   = 6;
  localparam int SRC_W    = 2;

  typedef enum logic [SRC_W-1:0] {
    SRC_NMI  = 2'd0,
    SRC_TMR  = 2'd1,
    SRC_DMA  = 2'd2,
    SRC_HOST = 2'd3
  } src_e;
endpackage

// File: rtl/cop_w1c_flags.sv
module cop_w1c_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk) begin
      if (!rst_n)          bit_q <= 1'b0;
      else if (set_i[b])   bit_q <= 1'b1;
      else if (clr_i[b])   bit_q <= 1'b0;
    end
    assign q_o[b] = bit_q;
  end

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/cop_irq_pick.sv
module cop_irq_pick
  import cop_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_i,
  input  logic [REG_W-1:0] ctrl_i,
  input  logic [REG_W-1:0] en_i,
  input  logic [REG_W-1:0] isr_i,
  input  logic             tmr_req_i,
  input  logic             dma_req_i,
  input  logic             irq_dis_i,
  output logic             halt_o,
  output logic             take_o,
  output src_e             src_o,
  output logic [REG_W-1:0] set_mask_o
);
  logic nmi_ok, tmr_ok, dma_ok, host_ok;
  logic unused_bits;

  assign unused_bits = ^{ctrl_i[3:0], en_i[4:0]};
  assign halt_o  = ctrl_i[HOLD_A] | ctrl_i[HOLD_B];
  assign nmi_ok  = ctrl_i[NMI_BIT] & ~isr_i[NMI_BIT];
  assign tmr_ok  = tmr_req_i & en_i[TMR_BIT] & ~isr_i[TMR_BIT];
  assign dma_ok  = dma_req_i & en_i[DMA_BIT] & ~isr_i[DMA_BIT];
  assign host_ok = ctrl_i[HOST_BIT] & en_i[HOST_BIT] & ~isr_i[HOST_BIT];

  always_comb begin
    take_o     = 1'b0;
    src_o      = SRC_NMI;
    set_mask_o = '0;
    if (fetch_i && !halt_o) begin
      if (nmi_ok) begin
        take_o = 1'b1;
        src_o  = SRC_NMI;
        set_mask_o[NMI_BIT] = 1'b1;
      end else if (!irq_dis_i) begin
        if (tmr_ok) begin
          take_o = 1'b1;
          src_o  = SRC_TMR;
          set_mask_o[TMR_BIT] = 1'b1;
        end else if (dma_ok) begin
          take_o = 1'b1;
          src_o  = SRC_DMA;
          set_mask_o[DMA_BIT] = 1'b1;
        end else if (host_ok) begin
          take_o = 1'b1;
          src_o  = SRC_HOST;
          set_mask_o[HOST_BIT] = 1'b1;
        end
      end
    end
  end

  a_r6_single_take: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(set_mask_o) <= 1);
  a_r2_hold_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |-> !take_o);
  a_r5_masked_only_nmi: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && irq_dis_i) |-> (src_o == SRC_NMI));
endmodule

// File: rtl/cop_irq_arbiter.sv
module cop_irq_arbiter
  import cop_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fetch_i,
  input  logic [7:0] ctrl_i,
  input  logic [7:0] en_i,
  input  logic       tmr_req_i,
  input  logic       dma_req_i,
  input  logic       irq_dis_i,
  input  logic       wait_i,
  input  logic [7:0] isr_ack_i,
  input  logic [7:0] sts_clr_i,
  output logic       vec_valid_o,
  output logic [1:0] vec_src_o,
  output logic       vec_nmi_o,
  output logic       vec_irq_o,
  output logic       pc_bump_o,
  output logic       halt_o,
  output logic [7:0] status_o,
  output logic [7:0] in_service_o
);
  logic             take;
  src_e             src;
  logic [REG_W-1:0] set_mask;

  cop_irq_pick u_pick (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_i    (fetch_i),
    .ctrl_i     (ctrl_i),
    .en_i       (en_i),
    .isr_i      (in_service_o),
    .tmr_req_i  (tmr_req_i),
    .dma_req_i  (dma_req_i),
    .irq_dis_i  (irq_dis_i),
    .halt_o     (halt_o),
    .take_o     (take),
    .src_o      (src),
    .set_mask_o (set_mask)
  );

  cop_w1c_flags #(.W(REG_W)) u_isr (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (set_mask),
    .clr_i (isr_ack_i),
    .q_o   (in_service_o)
  );

  cop_w1c_flags #(.W(REG_W)) u_sts (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (set_mask),
    .clr_i (sts_clr_i),
    .q_o   (status_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid_o <= 1'b0;
      vec_src_o   <= '0;
      vec_nmi_o   <= 1'b0;
      vec_irq_o   <= 1'b0;
      pc_bump_o   <= 1'b0;
    end else begin
      vec_valid_o <= take;
      vec_src_o   <= take ? src : '0;
      vec_nmi_o   <= take && (src == SRC_NMI);
      vec_irq_o   <= take && (src != SRC_NMI);
      pc_bump_o   <= take && wait_i;
    end
  end

  a_r10_vec_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> $past(fetch_i));
  a_r8_bump_with_vec: assert property (@(posedge clk) disable iff (!rst_n)
    pc_bump_o |-> (vec_valid_o && $past(wait_i)));
  a_r6_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> (vec_nmi_o ^ vec_irq_o));
  a_r3_nmi_marked: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && vec_nmi_o) |-> (in_service_o[NMI_BIT] && status_o[NMI_BIT]));
  a_r3_nmi_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_i && !halt_o && ctrl_i[NMI_BIT] && !in_service_o[NMI_BIT])
      |=> (vec_valid_o && vec_nmi_o));
  a_r2_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |=> !vec_valid_o);
endmodule

// File: tb/cop_irq_arbiter_bench.sv
`timescale 1ns/1ps
module cop_irq_arbiter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fetch_i = 1'b0;
  logic [7:0] ctrl_i = '0, en_i = '0, isr_ack_i = '0, sts_clr_i = '0;
  logic       tmr_req_i = 1'b0, dma_req_i = 1'b0, irq_dis_i = 1'b0, wait_i = 1'b0;
  logic       vec_valid_o, vec_nmi_o, vec_irq_o, pc_bump_o, halt_o;
  logic [1:0] vec_src_o;
  logic [7:0] status_o, in_service_o;

  int checks = 0, fails = 0, cycles = 0;
  logic [7:0] m_isr = '0, m_sts = '0;
  logic       e_valid = 0, e_nmi = 0, e_irq = 0, e_bump = 0;
  logic [1:0] e_src = 0;

  cop_irq_arbiter u_cop_irq_arbiter (.*);

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: run did not end, actual %0d cycles expected < 100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic compare(input string tag);
    checks++;
    if ({vec_valid_o, vec_src_o, vec_nmi_o, vec_irq_o, pc_bump_o, status_o, in_service_o} !==
        {e_valid, e_src, e_nmi, e_irq, e_bump, m_sts, m_isr}) begin
      fails++;
      $display("FAIL %s: actual v=%b id=%0d n=%b i=%b b=%b sts=%h isr=%h expected v=%b id=%0d n=%b i=%b b=%b sts=%h isr=%h",
        tag, vec_valid_o, vec_src_o, vec_nmi_o, vec_irq_o, pc_bump_o, status_o, in_service_o,
        e_valid, e_src, e_nmi, e_irq, e_bump, m_sts, m_isr);
    end
  endtask

  task automatic step(input string tag, input logic f, input logic [7:0] c, input logic [7:0] e,
                      input logic t, input logic d, input logic dis, input logic w,
                      input logic [7:0] ack, input logic [7:0] sclr);
    logic hold;
    int   id;
    fetch_i = f; ctrl_i = c; en_i = e; tmr_req_i = t; dma_req_i = d;
    irq_dis_i = dis; wait_i = w; isr_ack_i = ack; sts_clr_i = sclr;
    hold = c[5] | c[6];
    #1;
    checks++;
    if (halt_o !== hold) begin
      fails++;
      $display("FAIL R2 halt: actual %b expected %b", halt_o, hold);
    end
    id = -1;
    if (f && !hold) begin
      if (c[4] && !m_isr[4]) id = 0;
      else if (!dis) begin
        if (t && e[6] && !m_isr[6]) id = 1;
        else if (d && e[5] && !m_isr[5]) id = 2;
        else if (c[7] && e[7] && !m_isr[7]) id = 3;
      end
    end
    e_valid = (id >= 0);
    e_src   = (id >= 0) ? 2'(id) : 2'd0;
    e_nmi   = (id == 0);
    e_irq   = (id > 0);
    e_bump  = (id >= 0) && w;
    begin
      logic [7:0] sb;
      sb = '0;
      case (id)
        0: sb[4] = 1'b1;
        1: sb[6] = 1'b1;
        2: sb[5] = 1'b1;
        3: sb[7] = 1'b1;
        default: ;
      endcase
      m_isr = sb | (m_isr & ~ack);
      m_sts = sb | (m_sts & ~sclr);
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1'b1;
    // R10: no fetch, all requests up
    step("R10 no fetch", 0, 8'h90, 8'hE0, 1, 1, 0, 0, 0, 0);
    // R2: hold bits block everything
    step("R2 hold b5", 1, 8'hB0, 8'hE0, 1, 1, 0, 0, 0, 0);
    step("R2 hold b6", 1, 8'hD0, 8'hE0, 1, 1, 0, 1, 0, 0);
    // R3: NMI with interrupts disabled, from wait
    step("R3 nmi", 1, 8'h10, 8'h00, 0, 0, 1, 1, 0, 0);
    step("R8 bump once", 0, 8'h10, 8'h00, 0, 0, 1, 0, 0, 0);
    // R4: NMI in service, timer taken
    step("R4 nmi blocked", 1, 8'h10, 8'h40, 1, 0, 0, 0, 0, 0);
    // R5: disabled masks maskables
    step("R5 disabled", 1, 8'h80, 8'hE0, 0, 1, 1, 0, 0, 0);
    // R6: priority DMA over host
    step("R6 dma first", 1, 8'h80, 8'hE0, 1, 1, 0, 1, 0, 0);
    step("R6 host last", 1, 8'h80, 8'hE0, 1, 1, 0, 0, 0, 0);
    // R7: all in service, nothing more
    step("R7 all busy", 1, 8'h90, 8'hE0, 1, 1, 0, 0, 0, 0);
    // R9: ack timer, take again in same step as ack of DMA without enable
    step("R9 ack tmr", 0, 8'h00, 8'h00, 0, 0, 0, 0, 8'h40, 8'h00);
    step("R7 no enable", 1, 8'h00, 8'h00, 1, 0, 0, 0, 8'h20, 8'h00);
    step("R9 set wins", 1, 8'h00, 8'h40, 1, 0, 0, 0, 8'h40, 8'h40);
    step("R9 clear all", 0, 8'h00, 8'h00, 0, 0, 0, 0, 8'hFF, 8'hFF);
    step("R6 tmr first", 1, 8'h80, 8'hE0, 1, 1, 0, 0, 0, 0);
    for (int k = 0; k < 400; k++) begin
      logic [7:0] rc;
      rc = 8'($urandom) & 8'hF0;
      if ($urandom_range(3) != 0) rc[6:5] = 2'b00;
      step("R6 mixed", 1'($urandom), rc, 8'($urandom) & 8'hE0, 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), 8'($urandom) & 8'($urandom), 8'($urandom) & 8'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule